// File: doc/BRIEF.md
# Three-Protocol Host Bus Slave Port

This block connects a small 8-bit host processor to the register bus of a larger device. One set of pins serves three bus styles. In Intel non-multiplexed mode, separate read and write strobes move data and two address pins pick the register. In Intel multiplexed mode, the register index travels on the data pins during an address-latch phase. In Motorola non-multiplexed mode, a data strobe starts the transfer and a read/write level sets its direction. The level and history of the address-latch pin decide which style is in use, so a board straps or drives that pin and needs no further configuration.

Every strobe passes through a synchronizer into the internal clock domain. A qualified access then becomes a one-cycle register read pulse or a one-cycle register write pulse on an internal register bus. The neighbouring logic behind that bus holds the address and data registers that give indirect access to the switch memories. Read data is held and driven onto the bus while the read strobe stays active. A single open-drain style pull-down output works as a wait line in the Intel modes and as a transfer acknowledge in Motorola mode.

Top module: `host_bus_port`

## Requirements
- R1: During and after reset, with no strobe applied, `bus_oe`, `rdy_pull`, `reg_rd` and `reg_wr` are all 0.
- R2: In an Intel mode, let N be the first rising edge at which `cs_n` and `rd_n` are both low. `reg_rd` is high for the single cycle that follows edge N+2, with `reg_idx` holding the index. `bus_oe` rises at edge N+2. From edge N+3, `bus_out` carries the `reg_rdata` value sampled in the `reg_rd` cycle.
- R3: In an Intel mode, `rdy_pull` is 1 while the raw `cs_n` and `rd_n` are both low and the read data is not yet valid, and it falls at edge N+3. An Intel write never drives `rdy_pull`.
- R4: In an Intel mode, let M be the first rising edge at which the write strobe is seen high after a write. `reg_wr` is high for the single cycle that follows edge M+2. `reg_wdata` carries the bus value that was held through edge M+1, and `reg_idx` carries the index that was taken when the write began.
- R5: With the address-latch pin held high from reset, and no falling edge on it, the port works in Motorola mode. `cs_n` low with `rd_n` (data strobe) low starts an access. `wr_n` (read/write) high means a read and low means a write. The read and write timing is the same as in R2 and R4.
- R6: In Motorola mode, `rdy_pull` (acknowledge) is 1 while the raw data strobe and `cs_n` are low and the transfer is complete: from edge N+3 for a read and from edge N+2 for a write. It drops as soon as the strobe is released.
- R7: After reset, a falling edge on the address-latch pin selects Intel multiplexed mode, and that mode stays until the next reset. The register index is then `bus_in[1:0]` as last sampled while the pin was high. The `addr` pins are ignored.
- R8: While `cs_n` is high, no strobe produces `reg_rd`, `reg_wr`, `bus_oe` or `rdy_pull`.
- R9: In Motorola mode, a low on `wr_n` while the data strobe is high causes no access.
- R10: With the address-latch pin held low from reset, the port works in Intel non-multiplexed mode and takes the register index from `addr`.
- R11: `reg_rd` and `reg_wr` are never high together, and each is high for at most one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Register index pins, used only in non-multiplexed modes |
| ale | input | 1 | Address latch / mode select |
| rd_n | input | 1 | Intel read strobe or Motorola data strobe, active low |
| wr_n | input | 1 | Intel write strobe or Motorola read/write level |
| bus_in | input | 8 | Host data bus, input side |
| bus_out | output | 8 | Host data bus, output side |
| bus_oe | output | 1 | Data bus drive enable |
| rdy_pull | output | 1 | Pull-down enable for the wait/acknowledge line |
| reg_idx | output | 2 | Internal register index |
| reg_rd | output | 1 | One-cycle internal read pulse |
| reg_wr | output | 1 | One-cycle internal write pulse |
| reg_wdata | output | 8 | Internal write data |
| reg_rdata | input | 8 | Internal read data, valid combinationally from `reg_idx` |

## Verification
Every result is counted from the first rising edge that sees the raw strobe. Two synchronizer stages put the read pulse and the bus enable at edge N+2 and the read data at N+3. The Intel wait line releases at N+3. The Motorola acknowledge rises at N+2 for a write and at N+3 for a read, and the write pulse comes at M+2 after the strobe is released. The bench drives inputs on falling edges and counts falling edges from the drive point, so each sample lands one half period after the edge where its result is due. Write data is changed three cycles after release, which proves that the captured value is the one held through edge M+1. Accesses are spaced at least four cycles apart, so the acknowledge and wait state of one access has cleared before the next begins.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;
    typedef enum logic [1:0] {
        BM_INTEL = 2'd0,
        BM_MOTO  = 2'd1,
        BM_MUX   = 2'd2
    } bus_mode_e;
endpackage

// File: rtl/host_bus_sync.sv
module host_bus_sync #(
    parameter int W = 4,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) stage_d[i] = stage_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/host_bus_mode.sv
module host_bus_mode
    import host_bus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_raw,
    input  logic              ale_s,
    input  logic [DATA_W-1:0] bus_in,
    output bus_mode_e         mode,
    output logic [IDX_W-1:0]  lat_idx
);
    typedef struct packed {
        logic             prev;
        logic             mux;
        logic [IDX_W-1:0] lat;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.prev = ale_s;
        if (st_q.prev && !ale_s) st_d.mux = 1'b1;
        // latch tracks the bus while the raw pin is high; its last value stays
        if (ale_raw) st_d.lat = bus_in[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode    = st_q.mux ? BM_MUX : (ale_s ? BM_MOTO : BM_INTEL);
    assign lat_idx = st_q.lat;
endmodule

// File: rtl/host_bus_decode.sv
module host_bus_decode
    import host_bus_pkg::*;
(
    input  bus_mode_e mode,
    input  logic      cs_n,
    input  logic      rd_n,
    input  logic      wr_n,
    output logic      rd_act,
    output logic      wr_act
);
    always_comb begin
        if (mode == BM_MOTO) begin
            rd_act = !cs_n && !rd_n && wr_n;
            wr_act = !cs_n && !rd_n && !wr_n;
        end else begin
            rd_act = !cs_n && !rd_n;
            wr_act = !cs_n && !wr_n && rd_n;
        end
    end
endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
    import host_bus_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic [IDX_W-1:0]  addr,
    input  logic              ale,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              rdy_pull,
    output logic [IDX_W-1:0]  reg_idx,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] SYNC_RST = 4'b1110;

    logic [NSIG-1:0] sync_out;
    logic            s_cs_n, s_rd_n, s_wr_n, s_ale;
    bus_mode_e       cur_mode;
    logic [IDX_W-1:0] lat_idx;
    logic            rd_act, wr_act, raw_rd, raw_wr;
    logic [IDX_W-1:0] cur_idx;

    host_bus_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
        .clk(clk), .rst_n(rst_n),
        .din({cs_n, rd_n, wr_n, ale}),
        .dout(sync_out)
    );
    assign {s_cs_n, s_rd_n, s_wr_n, s_ale} = sync_out;

    host_bus_mode #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_mode (
        .clk(clk), .rst_n(rst_n), .ale_raw(ale), .ale_s(s_ale),
        .bus_in(bus_in), .mode(cur_mode), .lat_idx(lat_idx)
    );

    host_bus_decode i_dec_sync (
        .mode(cur_mode), .cs_n(s_cs_n), .rd_n(s_rd_n), .wr_n(s_wr_n),
        .rd_act(rd_act), .wr_act(wr_act)
    );

    host_bus_decode i_dec_raw (
        .mode(cur_mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rd_act(raw_rd), .wr_act(raw_wr)
    );

    assign cur_idx = (cur_mode == BM_MUX) ? lat_idx : addr;

    typedef struct packed {
        logic              act_rd;
        logic              act_wr;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              valid;
        logic              done;
        logic              rd_pls;
        logic              wr_pls;
        logic              oe;
    } acc_st_t;

    acc_st_t acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        acc_d.rd_pls = 1'b0;
        acc_d.wr_pls = 1'b0;
        acc_d.act_rd = rd_act;
        acc_d.act_wr = wr_act;
        acc_d.oe     = rd_act;
        if (rd_act && !acc_q.act_rd) begin
            acc_d.rd_pls = 1'b1;
            acc_d.idx    = cur_idx;
        end
        if (wr_act && !acc_q.act_wr) acc_d.idx = cur_idx;
        if (acc_q.rd_pls) begin
            acc_d.rdata = reg_rdata;
            acc_d.valid = 1'b1;
        end
        if (wr_act) begin
            acc_d.wdata = bus_in;
            acc_d.done  = 1'b1;
        end
        if (!wr_act && acc_q.act_wr) acc_d.wr_pls = 1'b1;
        if (!rd_act && !wr_act) begin
            acc_d.valid = 1'b0;
            acc_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    always_comb begin
        if (cur_mode == BM_MOTO) rdy_pull = (raw_rd && acc_q.valid) || (raw_wr && acc_q.done);
        else                     rdy_pull = raw_rd && !acc_q.valid;
    end

    assign bus_out   = acc_q.rdata;
    assign bus_oe    = acc_q.oe;
    assign reg_idx   = acc_q.idx;
    assign reg_rd    = acc_q.rd_pls;
    assign reg_wr    = acc_q.wr_pls;
    assign reg_wdata = acc_q.wdata;
endmodule

// File: rtl/host_bus_chk.sv
module host_bus_chk
    import host_bus_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_n,
    input bus_mode_e mode,
    input logic      bus_oe,
    input logic      rdy_pull,
    input logic      reg_rd,
    input logic      reg_wr
);
    a_r11_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    a_r11_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    a_r8_deselected_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
        |-> (!bus_oe && !reg_rd && !reg_wr));

    a_r6_pull_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_pull |-> !cs_n);

    a_r7_mux_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BM_MUX) |=> (mode == BM_MUX));
endmodule

bind host_bus_port host_bus_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .mode(cur_mode),
    .bus_oe(bus_oe), .rdy_pull(rdy_pull), .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/test_host_bus_port.sv
module test_host_bus_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic [1:0] addr = '0;
    logic       ale = 1'b0;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe, rdy_pull, reg_rd, reg_wr;
    logic [1:0] reg_idx;
    logic [7:0] reg_wdata, reg_rdata;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    int rd_count = 0;
    int r11_viol = 0;
    logic [1:0] last_widx;
    logic [7:0] last_wdata;
    logic [7:0] regs [4];
    logic       rd_prev, wr_prev;

    always #5 clk = ~clk;

    host_bus_port i_host_bus_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .rdy_pull(rdy_pull), .reg_idx(reg_idx),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_idx];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs[0] <= 8'h11; regs[1] <= 8'h22; regs[2] <= 8'h33; regs[3] <= 8'h44;
            rd_prev <= 1'b0; wr_prev <= 1'b0;
        end else begin
            if (reg_wr) begin
                regs[reg_idx] <= reg_wdata;
                wr_count <= wr_count + 1;
                last_widx <= reg_idx;
                last_wdata <= reg_wdata;
            end
            if (reg_rd) rd_count <= rd_count + 1;
            // R11: bench-side pulse shape monitor
            if ((reg_rd && reg_wr) || (reg_rd && rd_prev) || (reg_wr && wr_prev))
                r11_viol <= r11_viol + 1;
            rd_prev <= reg_rd;
            wr_prev <= reg_wr;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ale_lvl);
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ale = ale_lvl; addr = '0;
        step(3);
        chk("R1 oe in reset", bus_oe, 0);
        rst_n = 1'b1;
        step(5);
        chk("R1 oe idle", bus_oe, 0);
        chk("R1 pull idle", rdy_pull, 0);
        chk("R1 pulses idle", {30'b0, reg_rd, reg_wr}, 0);
    endtask

    task automatic intel_read(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        step(2);
        chk({tag, " R3 wait held"}, rdy_pull, 1);
        chk({tag, " R2 oe not yet"}, bus_oe, 0);
        step(1);
        chk({tag, " R2 oe at N+2"}, bus_oe, 1);
        chk({tag, " R2 read pulse"}, reg_rd, 1);
        step(1);
        chk({tag, " R2 read data"}, bus_out, exp);
        chk({tag, " R3 wait released"}, rdy_pull, 0);
        cs_n = 1'b1; rd_n = 1'b1;
        step(4);
        chk({tag, " R2 oe off"}, bus_oe, 0);
    endtask

    task automatic intel_write(input logic [1:0] a, input logic [7:0] d,
                               input logic [1:0] exp_idx, input string tag);
        int c0;
        @(negedge clk);
        c0 = wr_count;
        cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; bus_in = d;
        step(3);
        chk({tag, " R3 no wait on write"}, rdy_pull, 0);
        step(2);
        cs_n = 1'b1; wr_n = 1'b1;
        step(3);
        bus_in = ~d;
        step(3);
        chk({tag, " R4 one write"}, wr_count, c0 + 1);
        chk({tag, " R4 write data"}, last_wdata, d);
        chk({tag, " R4 write index"}, last_widx, exp_idx);
    endtask

    task automatic moto_read(input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        step(2);
        chk("R6 no ack yet", rdy_pull, 0);
        step(2);
        chk("R5 moto read data", bus_out, exp);
        chk("R6 read ack", rdy_pull, 1);
        cs_n = 1'b1; rd_n = 1'b1;
        step(1);
        chk("R6 ack dropped", rdy_pull, 0);
        step(4);
    endtask

    task automatic moto_write(input logic [1:0] a, input logic [7:0] d);
        int c0;
        @(negedge clk);
        c0 = wr_count;
        cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0; addr = a; bus_in = d;
        step(2);
        chk("R6 write ack not yet", rdy_pull, 0);
        step(1);
        chk("R6 write ack", rdy_pull, 1);
        step(2);
        cs_n = 1'b1; rd_n = 1'b1;
        step(1);
        chk("R6 write ack dropped", rdy_pull, 0);
        step(2);
        wr_n = 1'b1; bus_in = ~d;
        step(4);
        chk("R5 moto write count", wr_count, c0 + 1);
        chk("R5 moto write data", last_wdata, d);
    endtask

    task automatic deselected_strobes();
        int w0, r0;
        @(negedge clk);
        w0 = wr_count; r0 = rd_count;
        cs_n = 1'b1; rd_n = 1'b0;
        step(6);
        chk("R8 no oe deselected", bus_oe, 0);
        chk("R8 no wait deselected", rdy_pull, 0);
        rd_n = 1'b1; wr_n = 1'b0;
        step(6);
        wr_n = 1'b1;
        step(5);
        chk("R8 no pulses deselected", (wr_count - w0) + (rd_count - r0), 0);
    endtask

    task automatic moto_rw_alone();
        int w0, r0;
        @(negedge clk);
        w0 = wr_count; r0 = rd_count;
        cs_n = 1'b0; rd_n = 1'b1; wr_n = 1'b0;
        step(6);
        chk("R9 no oe", bus_oe, 0);
        chk("R9 no ack", rdy_pull, 0);
        cs_n = 1'b1; wr_n = 1'b1;
        step(5);
        chk("R9 no access", (wr_count - w0) + (rd_count - r0), 0);
    endtask

    task automatic mux_latch(input logic [1:0] idx);
        @(negedge clk);
        ale = 1'b1; bus_in = {6'b101010, idx};
        step(2);
        ale = 1'b0;
        step(1);
        bus_in = {6'b010101, ~idx};
        step(4);
    endtask

    initial begin
        #100us;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Intel non-multiplexed (R10)
        do_reset(1'b0);
        intel_read(2'd1, 8'h22, "R10");
        intel_write(2'd2, 8'hA5, 2'd2, "R10");
        intel_read(2'd2, 8'hA5, "R10 readback");
        deselected_strobes();
        // Motorola
        do_reset(1'b1);
        moto_read(2'd3, 8'h44);
        moto_write(2'd0, 8'h5A);
        moto_read(2'd0, 8'h5A);
        moto_rw_alone();
        // Intel multiplexed (R7)
        do_reset(1'b0);
        mux_latch(2'd1);
        intel_read(2'd3, 8'h22, "R7 pins ignored");
        mux_latch(2'd2);
        intel_write(2'd0, 8'h3C, 2'd2, "R7");
        mux_latch(2'd2);
        intel_read(2'd1, 8'h3C, "R7 readback");
        chk("R11 pulse shape", r11_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule